// File: doc/BRIEF.md
# Per-Thread Fetch Stall and Squash Arbiter

This block sits beside the instruction fetch stage of a multithreaded out-of-order core. Every cycle it gathers stall and release pulses from the four stages downstream of fetch (decode, rename, execute and commit). It also gathers squash indications from commit and from decode. From these it keeps, for each hardware thread, a set of stall flags and a fetch status. Its outputs tell the fetch engine whether a thread may fetch, where to restart it after a squash, and which command to send to the branch predictor.

Squash sources resolve by a fixed priority within each thread. A commit squash wins. Below it, a reorder-buffer flush still in progress pins the thread in the squashing state. A decode squash comes last, and its redirect is dropped when the thread is already squashing. A squash also cancels the thread's outstanding cache-response wait and frees the single shared retry slot if that thread holds it. The block summarises all threads into one stage-active bit and pulses once whenever that bit changes.

Top module: `fss_arbiter`

## Requirements
- R1: Each thread has four stall flags held in `stall_src` at bit thread*4+source, with source 0=decode, 1=rename, 2=execute, 3=commit. A block pulse sets its flag and an unblock pulse clears it, visible from the next cycle. Block and unblock for the same flag never arrive together.
- R2: `stalled[t]` is high in the same cycle whenever `ctx_switch` is high, and whenever any of thread t's four flags is set.
- R3: `stall_cause` (3 bits per thread) reports the winning stall reason in the order context switch=1, decode=2, rename=3, execute=4, commit=5, and none=0.
- R4: A commit squash produces, one cycle later, a one-cycle `redir_valid` with the commit PC, NPC and micro-PC. It sets the thread status to squashing (1) and issues a predictor squash carrying the commit sequence number, mispredict flag, target PC and taken flag.
- R5: A commit done report without a commit squash produces, one cycle later, a one-cycle `bpu_valid` with that sequence number. A commit squash in the same cycle suppresses it.
- R6: A reorder-buffer squash in progress, with no commit squash, sets the status to squashing without a redirect. A decode squash in that same cycle has no effect on the redirect, the status or the predictor.
- R7: A decode squash, when no commit squash or reorder-buffer squash is present, always issues a predictor squash with the decode fields. It redirects to the decode PC/NPC/micro-PC and sets the status to squashing only if the thread's status is not already squashing.
- R8: A redirecting squash on a thread whose status is wait-response (2) gives a one-cycle `wait_cancel` pulse for that thread. A redirecting squash on the thread that owns the retry slot frees the slot.
- R9: Status codes are running=0, squashing=1, wait-response=2, wait-retry=3, access-complete=4. A fetch-engine update (`fe_upd`, `fe_code`) takes effect the next cycle only when the thread neither redirects nor holds for a reorder-buffer squash. Codes above 4 are ignored.
- R10: A retry claim is taken only while the slot is free, and records the claiming thread as owner. `retry_release` frees a busy slot.
- R11: `stage_active` is set when at least one thread marked active in `thread_active` has a next status of running, squashing or access-complete. `act_pulse` and `deact_pulse` fire for exactly one cycle when it rises or falls.
- R12: During reset every status is running, every flag is clear, the retry slot is free, and all redirect, predictor and activity outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_switch | input | 1 | Context switch in progress, stalls every thread |
| thread_active | input | NT | Threads that count toward stage activity |
| blk_pulse | input | NT*4 | Block pulses, bit thread*4+source |
| unb_pulse | input | NT*4 | Unblock pulses, same layout |
| cmt_squash | input | NT | Commit squash per thread |
| cmt_mispredict | input | NT | Commit squash was a mispredict |
| cmt_taken | input | NT | Resolved direction of the mispredicted branch |
| cmt_done | input | NT | Commit reports a completed sequence number |
| cmt_seq | input | NT*SEQ_W | Commit sequence number |
| cmt_pc | input | NT*ADDR_W | Commit restart PC |
| cmt_npc | input | NT*ADDR_W | Commit restart NPC |
| cmt_upc | input | NT*UPC_W | Commit restart micro-PC |
| rob_squashing | input | NT | Reorder-buffer flush still in progress |
| dec_squash | input | NT | Decode squash per thread |
| dec_mispredict | input | NT | Decode squash was a mispredict |
| dec_taken | input | NT | Decode-resolved direction |
| dec_seq | input | NT*SEQ_W | Decode sequence number |
| dec_pc | input | NT*ADDR_W | Decode restart PC |
| dec_npc | input | NT*ADDR_W | Decode restart NPC |
| dec_upc | input | NT*UPC_W | Decode restart micro-PC |
| fe_upd | input | NT | Fetch-engine status update strobe |
| fe_code | input | NT*3 | Fetch-engine status code |
| retry_claim | input | 1 | Request to take the retry slot |
| retry_tid | input | TID_W | Thread requesting the retry slot |
| retry_release | input | 1 | Retry completed, free the slot |
| stall_src | output | NT*4 | Stall flags |
| stalled | output | NT | Thread may not fetch |
| stall_cause | output | NT*3 | Highest-priority stall reason |
| status | output | NT*3 | Thread fetch status |
| redir_valid | output | NT | Redirect pulse |
| redir_pc | output | NT*ADDR_W | Redirect PC |
| redir_npc | output | NT*ADDR_W | Redirect NPC |
| redir_upc | output | NT*UPC_W | Redirect micro-PC |
| bps_valid | output | NT | Predictor squash command |
| bps_misp | output | NT | Predictor squash carries a correction |
| bps_taken | output | NT | Corrected direction |
| bps_seq | output | NT*SEQ_W | Predictor squash sequence number |
| bps_pc | output | NT*ADDR_W | Corrected target |
| bpu_valid | output | NT | Predictor update command |
| bpu_seq | output | NT*SEQ_W | Predictor update sequence number |
| wait_cancel | output | NT | Outstanding cache wait cancelled |
| retry_busy | output | 1 | Retry slot occupied |
| retry_owner | output | TID_W | Retry slot owner |
| stage_active | output | 1 | Fetch stage has work |
| act_pulse | output | 1 | Stage became active |
| deact_pulse | output | 1 | Stage became inactive |

## Verification
On every cycle, the bound checker covers several rules. Flags follow their block and unblock pulses one cycle later. A commit squash always yields a redirect into the squashing state and never a predictor update. A reorder-buffer flush holds the status without a redirect. The activity pulses line up with the edges of `stage_active`, and a squash of the owner empties the retry slot. Other behaviour can only be shown by the bench scenarios. These cover the conditional decode redirect against the current status, the order of the stall causes and the squash priorities, the exact redirect and predictor field values, the rejection of unknown status codes, and the exclusion of inactive threads from the activity summary.

// File: rtl/fss_pkg.sv
package fss_pkg;

  localparam int NSRC = 4;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SQ     = 3'd1,
    ST_WRESP  = 3'd2,
    ST_WRETRY = 3'd3,
    ST_DONE   = 3'd4
  } fstat_e;

  typedef enum logic [2:0] {
    CZ_NONE = 3'd0,
    CZ_CTX  = 3'd1,
    CZ_DEC  = 3'd2,
    CZ_REN  = 3'd3,
    CZ_EXE  = 3'd4,
    CZ_CMT  = 3'd5
  } stall_cause_e;

  function automatic logic fstat_awake(input logic [2:0] s);
    return (s == ST_RUN) || (s == ST_SQ) || (s == ST_DONE);
  endfunction

endpackage

// File: rtl/fss_stall_flags.sv
module fss_stall_flags
  import fss_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctx_switch,
  input  logic [NT*NSRC-1:0] blk,
  input  logic [NT*NSRC-1:0] unb,
  output logic [NT*NSRC-1:0] flags,
  output logic [NT-1:0]      stalled,
  output logic [NT*3-1:0]    cause
);

  logic [NT*NSRC-1:0] flags_q, flags_d;
  logic               flags_en;

  always_comb begin
    flags_en = |(blk | unb);
    flags_d  = (flags_q & ~unb) | blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [NSRC-1:0] f;
    stall_cause_e    c;

    assign f = flags_q[t*NSRC +: NSRC];

    always_comb begin
      if (ctx_switch)   c = CZ_CTX;
      else if (f[0])    c = CZ_DEC;
      else if (f[1])    c = CZ_REN;
      else if (f[2])    c = CZ_EXE;
      else if (f[3])    c = CZ_CMT;
      else              c = CZ_NONE;
    end

    assign stalled[t]     = ctx_switch | (|f);
    assign cause[t*3 +: 3] = c;
  end

endmodule

// File: rtl/fss_thread_ctl.sv
module fss_thread_ctl
  import fss_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int UPC_W  = 8,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_sq,
  input  logic              cmt_misp,
  input  logic              cmt_tkn,
  input  logic              cmt_done,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic [ADDR_W-1:0] cmt_pc,
  input  logic [ADDR_W-1:0] cmt_npc,
  input  logic [UPC_W-1:0]  cmt_upc,
  input  logic              rob_sq,
  input  logic              dec_sq,
  input  logic              dec_misp,
  input  logic              dec_tkn,
  input  logic [SEQ_W-1:0]  dec_seq,
  input  logic [ADDR_W-1:0] dec_pc,
  input  logic [ADDR_W-1:0] dec_npc,
  input  logic [UPC_W-1:0]  dec_upc,
  input  logic              fe_upd,
  input  logic [2:0]        fe_code,
  output logic [2:0]        st_o,
  output logic [2:0]        st_next_o,
  output logic              fire_o,
  output logic              rv_o,
  output logic [ADDR_W-1:0] rpc_o,
  output logic [ADDR_W-1:0] rnpc_o,
  output logic [UPC_W-1:0]  rupc_o,
  output logic              bps_v_o,
  output logic              bps_m_o,
  output logic              bps_t_o,
  output logic [SEQ_W-1:0]  bps_seq_o,
  output logic [ADDR_W-1:0] bps_pc_o,
  output logic              bpu_v_o,
  output logic [SEQ_W-1:0]  bpu_seq_o,
  output logic              wc_o
);

  fstat_e st_q, st_d;
  logic   take_cmt, take_rob, take_dec, dec_redir, fire;
  logic   bps_fire, upd_fire, wc_fire;

  logic [ADDR_W-1:0] rpc_q, rnpc_q, bpc_q, rpc_d, rnpc_d;
  logic [UPC_W-1:0]  rupc_q, rupc_d;
  logic [SEQ_W-1:0]  bseq_q, useq_q, bseq_d;
  logic              rv_q, bv_q, bm_q, bt_q, bm_d, bt_d, uv_q, wc_q;

  // squash source priority and status next state
  always_comb begin
    take_cmt  = cmt_sq;
    take_rob  = !cmt_sq && rob_sq;
    take_dec  = !cmt_sq && !rob_sq && dec_sq;
    dec_redir = take_dec && (st_q != ST_SQ);
    fire      = take_cmt || dec_redir;
    bps_fire  = take_cmt || take_dec;
    upd_fire  = !cmt_sq && cmt_done;
    wc_fire   = fire && (st_q == ST_WRESP);

    if (fire || take_rob)                 st_d = ST_SQ;
    else if (fe_upd && fe_code <= 3'd4)   st_d = fstat_e'(fe_code);
    else                                  st_d = st_q;
  end

  // payload selection
  always_comb begin
    rpc_d  = take_cmt ? cmt_pc   : dec_pc;
    rnpc_d = take_cmt ? cmt_npc  : dec_npc;
    rupc_d = take_cmt ? cmt_upc  : dec_upc;
    bm_d   = take_cmt ? cmt_misp : dec_misp;
    bt_d   = take_cmt ? cmt_tkn  : dec_tkn;
    bseq_d = take_cmt ? cmt_seq  : dec_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_RUN;
      rv_q <= 1'b0;
      bv_q <= 1'b0;
      uv_q <= 1'b0;
      wc_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rv_q <= fire;
      bv_q <= bps_fire;
      uv_q <= upd_fire;
      wc_q <= wc_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpc_q  <= '0;
      rnpc_q <= '0;
      rupc_q <= '0;
    end else if (fire) begin
      rpc_q  <= rpc_d;
      rnpc_q <= rnpc_d;
      rupc_q <= rupc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bm_q   <= 1'b0;
      bt_q   <= 1'b0;
      bseq_q <= '0;
      bpc_q  <= '0;
    end else if (bps_fire) begin
      bm_q   <= bm_d;
      bt_q   <= bt_d;
      bseq_q <= bseq_d;
      bpc_q  <= rpc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      useq_q <= '0;
    end else if (upd_fire) begin
      useq_q <= cmt_seq;
    end
  end

  assign st_o      = st_q;
  assign st_next_o = st_d;
  assign fire_o    = fire;
  assign rv_o      = rv_q;
  assign rpc_o     = rpc_q;
  assign rnpc_o    = rnpc_q;
  assign rupc_o    = rupc_q;
  assign bps_v_o   = bv_q;
  assign bps_m_o   = bm_q;
  assign bps_t_o   = bt_q;
  assign bps_seq_o = bseq_q;
  assign bps_pc_o  = bpc_q;
  assign bpu_v_o   = uv_q;
  assign bpu_seq_o = useq_q;
  assign wc_o      = wc_q;

endmodule

// File: rtl/fss_retry_slot.sv
module fss_retry_slot #(
  parameter int NT    = 2,
  parameter int TID_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim,
  input  logic [TID_W-1:0] claim_tid,
  input  logic             rel,
  input  logic [NT-1:0]    sq_fire,
  output logic             busy,
  output logic [TID_W-1:0] owner
);

  logic             busy_q, busy_d;
  logic [TID_W-1:0] owner_q, owner_d;
  logic             slot_en;

  always_comb begin
    busy_d  = busy_q;
    owner_d = owner_q;
    if (busy_q) begin
      if (sq_fire[owner_q] || rel) busy_d = 1'b0;
    end else if (claim && !sq_fire[claim_tid]) begin
      busy_d  = 1'b1;
      owner_d = claim_tid;
    end
    slot_en = (busy_d != busy_q) || (owner_d != owner_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (slot_en) begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
    end
  end

  assign busy  = busy_q;
  assign owner = owner_q;

endmodule

// File: rtl/fss_activity.sv
module fss_activity
  import fss_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] thread_active,
  input  logic [NT*3-1:0] st_next,
  output logic          stage_active,
  output logic          act_pulse,
  output logic          deact_pulse
);

  logic [NT-1:0] awake;
  logic          awake_any;
  logic          stage_q, act_q, deact_q;

  for (genvar t = 0; t < NT; t++) begin : g_awk
    assign awake[t] = thread_active[t] && fstat_awake(st_next[t*3 +: 3]);
  end

  assign awake_any = |awake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      act_q   <= 1'b0;
      deact_q <= 1'b0;
    end else begin
      stage_q <= awake_any;
      act_q   <= awake_any && !stage_q;
      deact_q <= !awake_any && stage_q;
    end
  end

  assign stage_active = stage_q;
  assign act_pulse    = act_q;
  assign deact_pulse  = deact_q;

endmodule

// File: rtl/fss_arbiter.sv
module fss_arbiter
  import fss_pkg::*;
#(
  parameter int NT     = 2,
  parameter int ADDR_W = 32,
  parameter int UPC_W  = 8,
  parameter int SEQ_W  = 16,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctx_switch,
  input  logic [NT-1:0]        thread_active,
  input  logic [NT*4-1:0]      blk_pulse,
  input  logic [NT*4-1:0]      unb_pulse,
  input  logic [NT-1:0]        cmt_squash,
  input  logic [NT-1:0]        cmt_mispredict,
  input  logic [NT-1:0]        cmt_taken,
  input  logic [NT-1:0]        cmt_done,
  input  logic [NT*SEQ_W-1:0]  cmt_seq,
  input  logic [NT*ADDR_W-1:0] cmt_pc,
  input  logic [NT*ADDR_W-1:0] cmt_npc,
  input  logic [NT*UPC_W-1:0]  cmt_upc,
  input  logic [NT-1:0]        rob_squashing,
  input  logic [NT-1:0]        dec_squash,
  input  logic [NT-1:0]        dec_mispredict,
  input  logic [NT-1:0]        dec_taken,
  input  logic [NT*SEQ_W-1:0]  dec_seq,
  input  logic [NT*ADDR_W-1:0] dec_pc,
  input  logic [NT*ADDR_W-1:0] dec_npc,
  input  logic [NT*UPC_W-1:0]  dec_upc,
  input  logic [NT-1:0]        fe_upd,
  input  logic [NT*3-1:0]      fe_code,
  input  logic                 retry_claim,
  input  logic [TID_W-1:0]     retry_tid,
  input  logic                 retry_release,
  output logic [NT*4-1:0]      stall_src,
  output logic [NT-1:0]        stalled,
  output logic [NT*3-1:0]      stall_cause,
  output logic [NT*3-1:0]      status,
  output logic [NT-1:0]        redir_valid,
  output logic [NT*ADDR_W-1:0] redir_pc,
  output logic [NT*ADDR_W-1:0] redir_npc,
  output logic [NT*UPC_W-1:0]  redir_upc,
  output logic [NT-1:0]        bps_valid,
  output logic [NT-1:0]        bps_misp,
  output logic [NT-1:0]        bps_taken,
  output logic [NT*SEQ_W-1:0]  bps_seq,
  output logic [NT*ADDR_W-1:0] bps_pc,
  output logic [NT-1:0]        bpu_valid,
  output logic [NT*SEQ_W-1:0]  bpu_seq,
  output logic [NT-1:0]        wait_cancel,
  output logic                 retry_busy,
  output logic [TID_W-1:0]     retry_owner,
  output logic                 stage_active,
  output logic                 act_pulse,
  output logic                 deact_pulse
);

  logic [NT*3-1:0] st_next;
  logic [NT-1:0]   sq_fire;

  fss_stall_flags #(.NT(NT)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctx_switch (ctx_switch),
    .blk        (blk_pulse),
    .unb        (unb_pulse),
    .flags      (stall_src),
    .stalled    (stalled),
    .cause      (stall_cause)
  );

  for (genvar t = 0; t < NT; t++) begin : g_thr
    fss_thread_ctl #(.ADDR_W(ADDR_W), .UPC_W(UPC_W), .SEQ_W(SEQ_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmt_sq    (cmt_squash[t]),
      .cmt_misp  (cmt_mispredict[t]),
      .cmt_tkn   (cmt_taken[t]),
      .cmt_done  (cmt_done[t]),
      .cmt_seq   (cmt_seq[t*SEQ_W +: SEQ_W]),
      .cmt_pc    (cmt_pc[t*ADDR_W +: ADDR_W]),
      .cmt_npc   (cmt_npc[t*ADDR_W +: ADDR_W]),
      .cmt_upc   (cmt_upc[t*UPC_W +: UPC_W]),
      .rob_sq    (rob_squashing[t]),
      .dec_sq    (dec_squash[t]),
      .dec_misp  (dec_mispredict[t]),
      .dec_tkn   (dec_taken[t]),
      .dec_seq   (dec_seq[t*SEQ_W +: SEQ_W]),
      .dec_pc    (dec_pc[t*ADDR_W +: ADDR_W]),
      .dec_npc   (dec_npc[t*ADDR_W +: ADDR_W]),
      .dec_upc   (dec_upc[t*UPC_W +: UPC_W]),
      .fe_upd    (fe_upd[t]),
      .fe_code   (fe_code[t*3 +: 3]),
      .st_o      (status[t*3 +: 3]),
      .st_next_o (st_next[t*3 +: 3]),
      .fire_o    (sq_fire[t]),
      .rv_o      (redir_valid[t]),
      .rpc_o     (redir_pc[t*ADDR_W +: ADDR_W]),
      .rnpc_o    (redir_npc[t*ADDR_W +: ADDR_W]),
      .rupc_o    (redir_upc[t*UPC_W +: UPC_W]),
      .bps_v_o   (bps_valid[t]),
      .bps_m_o   (bps_misp[t]),
      .bps_t_o   (bps_taken[t]),
      .bps_seq_o (bps_seq[t*SEQ_W +: SEQ_W]),
      .bps_pc_o  (bps_pc[t*ADDR_W +: ADDR_W]),
      .bpu_v_o   (bpu_valid[t]),
      .bpu_seq_o (bpu_seq[t*SEQ_W +: SEQ_W]),
      .wc_o      (wait_cancel[t])
    );
  end

  fss_retry_slot #(.NT(NT), .TID_W(TID_W)) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .claim     (retry_claim),
    .claim_tid (retry_tid),
    .rel       (retry_release),
    .sq_fire   (sq_fire),
    .busy      (retry_busy),
    .owner     (retry_owner)
  );

  fss_activity #(.NT(NT)) u_act (
    .clk           (clk),
    .rst_n         (rst_n),
    .thread_active (thread_active),
    .st_next       (st_next),
    .stage_active  (stage_active),
    .act_pulse     (act_pulse),
    .deact_pulse   (deact_pulse)
  );

endmodule

// File: rtl/fss_arbiter_chk.sv
module fss_arbiter_chk #(
  parameter int NT    = 2,
  parameter int TID_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NT*4-1:0]  blk_pulse,
  input logic [NT*4-1:0]  unb_pulse,
  input logic [NT*4-1:0]  stall_src,
  input logic [NT-1:0]    cmt_squash,
  input logic [NT-1:0]    rob_squashing,
  input logic [NT-1:0]    redir_valid,
  input logic [NT*3-1:0]  status,
  input logic [NT-1:0]    bpu_valid,
  input logic             stage_active,
  input logic             act_pulse,
  input logic             deact_pulse,
  input logic             retry_busy,
  input logic [TID_W-1:0] retry_owner
);

  AST_NO_BLK_UNB_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_pulse & unb_pulse) == '0); // R1

  for (genvar i = 0; i < NT*4; i++) begin : g_flag
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      blk_pulse[i] |=> stall_src[i]); // R1
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      unb_pulse[i] |=> !stall_src[i]); // R1
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    AST_CMT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash[t] |=> (redir_valid[t] && status[t*3 +: 3] == 3'd1)); // R4
    AST_UPD_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash[t] |=> !bpu_valid[t]); // R5
    AST_ROB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_squashing[t] && !cmt_squash[t]) |=>
        (status[t*3 +: 3] == 3'd1 && !redir_valid[t])); // R6
  end

  AST_RETRY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_busy && cmt_squash[retry_owner]) |=> !retry_busy); // R8

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_pulse && deact_pulse)); // R11
  AST_ACT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_active) |-> act_pulse); // R11
  AST_DEACT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stage_active) |-> deact_pulse); // R11

endmodule

bind fss_arbiter fss_arbiter_chk #(.NT(NT), .TID_W(TID_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .blk_pulse     (blk_pulse),
  .unb_pulse     (unb_pulse),
  .stall_src     (stall_src),
  .cmt_squash    (cmt_squash),
  .rob_squashing (rob_squashing),
  .redir_valid   (redir_valid),
  .status        (status),
  .bpu_valid     (bpu_valid),
  .stage_active  (stage_active),
  .act_pulse     (act_pulse),
  .deact_pulse   (deact_pulse),
  .retry_busy    (retry_busy),
  .retry_owner   (retry_owner)
);

// File: tb/fss_arbiter_bench.sv
module fss_arbiter_bench;

  localparam int NT = 2;
  localparam int AW = 32;
  localparam int UW = 8;
  localparam int SW = 16;

  logic clk, rst_n, ctx_switch;
  logic [NT-1:0]    thread_active;
  logic [NT*4-1:0]  blk_pulse, unb_pulse;
  logic [NT-1:0]    cmt_squash, cmt_mispredict, cmt_taken, cmt_done, rob_squashing;
  logic [NT-1:0]    dec_squash, dec_mispredict, dec_taken, fe_upd;
  logic [NT*SW-1:0] cmt_seq, dec_seq;
  logic [NT*AW-1:0] cmt_pc, cmt_npc, dec_pc, dec_npc;
  logic [NT*UW-1:0] cmt_upc, dec_upc;
  logic [NT*3-1:0]  fe_code;
  logic             retry_claim, retry_release;
  logic [0:0]       retry_tid;

  logic [NT*4-1:0]  stall_src;
  logic [NT-1:0]    stalled, redir_valid, bps_valid, bps_misp, bps_taken, bpu_valid, wait_cancel;
  logic [NT*3-1:0]  stall_cause, status;
  logic [NT*AW-1:0] redir_pc, redir_npc, bps_pc;
  logic [NT*UW-1:0] redir_upc;
  logic [NT*SW-1:0] bps_seq, bpu_seq;
  logic             retry_busy, stage_active, act_pulse, deact_pulse;
  logic [0:0]       retry_owner;

  int total = 0;
  int bad   = 0;

  fss_arbiter #(.NT(NT), .ADDR_W(AW), .UPC_W(UW), .SEQ_W(SW)) u_fss_arbiter (
    .clk(clk), .rst_n(rst_n), .ctx_switch(ctx_switch), .thread_active(thread_active),
    .blk_pulse(blk_pulse), .unb_pulse(unb_pulse),
    .cmt_squash(cmt_squash), .cmt_mispredict(cmt_mispredict), .cmt_taken(cmt_taken),
    .cmt_done(cmt_done), .cmt_seq(cmt_seq), .cmt_pc(cmt_pc), .cmt_npc(cmt_npc),
    .cmt_upc(cmt_upc), .rob_squashing(rob_squashing),
    .dec_squash(dec_squash), .dec_mispredict(dec_mispredict), .dec_taken(dec_taken),
    .dec_seq(dec_seq), .dec_pc(dec_pc), .dec_npc(dec_npc), .dec_upc(dec_upc),
    .fe_upd(fe_upd), .fe_code(fe_code),
    .retry_claim(retry_claim), .retry_tid(retry_tid), .retry_release(retry_release),
    .stall_src(stall_src), .stalled(stalled), .stall_cause(stall_cause), .status(status),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_npc(redir_npc),
    .redir_upc(redir_upc), .bps_valid(bps_valid), .bps_misp(bps_misp),
    .bps_taken(bps_taken), .bps_seq(bps_seq), .bps_pc(bps_pc),
    .bpu_valid(bpu_valid), .bpu_seq(bpu_seq), .wait_cancel(wait_cancel),
    .retry_busy(retry_busy), .retry_owner(retry_owner),
    .stage_active(stage_active), .act_pulse(act_pulse), .deact_pulse(deact_pulse)
  );

  always #5 clk = ~clk;

  // thread0 table: stim {csq, misp, done, rob, dsq, fupd, fcode[2:0]}
  //                exp  {st[2:0], rv, rsrc_dec, bps, bmisp, bpu}
  localparam logic [16:0] VEC [13] = '{
    {9'b000001010, 8'b01000000},  // R9  engine sets wait-response
    {9'b001000000, 8'b01000001},  // R5  done only -> update
    {9'b111000000, 8'b00110110},  // R4 R5 commit squash, update suppressed
    {9'b000010000, 8'b00100100},  // R7  decode squash while squashing
    {9'b000001000, 8'b00000000},  // R9  back to running
    {9'b010010000, 8'b00111110},  // R7  decode squash redirects
    {9'b000001000, 8'b00000000},  // R9
    {9'b001110000, 8'b00100001},  // R6  rob hold masks decode squash
    {9'b100001000, 8'b00110100},  // R9  commit squash beats engine update
    {9'b000001100, 8'b10000000},  // R9  access-complete
    {9'b000000000, 8'b10000000},  // R9  holds
    {9'b000011000, 8'b00111100},  // R7  decode redirects from complete
    {9'b000001000, 8'b00000000}   // R9
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic clr();
    blk_pulse = '0; unb_pulse = '0;
    cmt_squash = '0; cmt_mispredict = '0; cmt_done = '0; rob_squashing = '0;
    dec_squash = '0; dec_mispredict = '0; fe_upd = '0; fe_code = '0;
    retry_claim = 1'b0; retry_release = 1'b0; retry_tid = '0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [16:0] vv;
  logic [2:0]  prev_st;

  initial begin
    clk = 1'b0; rst_n = 1'b0; ctx_switch = 1'b0; thread_active = 2'b11;
    cmt_taken = 2'b11; dec_taken = 2'b11;
    cmt_seq = {16'h0B0B, 16'h0A0A}; dec_seq = {16'h0D0D, 16'h0C0C};
    cmt_pc  = {32'h1100, 32'h1000}; cmt_npc = {32'h1104, 32'h1004};
    dec_pc  = {32'h2100, 32'h2000}; dec_npc = {32'h2104, 32'h2004};
    cmt_upc = {8'h11, 8'h01};       dec_upc = {8'h21, 8'h02};
    clr();

    repeat (3) @(negedge clk);
    chk("R12 status", 64'(status), 64'h0);
    chk("R12 outputs", 64'({redir_valid, bps_valid, bpu_valid, stalled, stall_src,
                            retry_busy, stage_active, act_pulse, deact_pulse}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 activate", 64'({stage_active, act_pulse}), 64'h3);
    @(negedge clk);
    chk("R11 single pulse", 64'({stage_active, act_pulse}), 64'h2);

    prev_st = 3'd0;
    for (int i = 0; i < 13; i++) begin
      vv = VEC[i];
      cmt_squash[0] = vv[16]; cmt_mispredict[0] = vv[15]; dec_mispredict[0] = vv[15];
      cmt_done[0] = vv[14]; rob_squashing[0] = vv[13]; dec_squash[0] = vv[12];
      fe_upd[0] = vv[11]; fe_code[2:0] = vv[10:8];
      @(negedge clk);
      chk("R9 table status", 64'(status[2:0]), 64'(vv[7:5]));
      chk("R4 R7 table redirect", 64'(redir_valid[0]), 64'(vv[4]));
      if (vv[4])
        chk("R4 R7 table redirect pc", 64'(redir_pc[31:0]), vv[3] ? 64'h2000 : 64'h1000);
      chk("R6 R7 table pred squash", 64'(bps_valid[0]), 64'(vv[2]));
      if (vv[2])
        chk("R4 R7 table pred fields", 64'({bps_misp[0], bps_seq[15:0]}),
            64'({vv[1], vv[16] ? 16'h0A0A : 16'h0C0C}));
      chk("R5 table update", 64'(bpu_valid[0]), 64'(vv[0]));
      if (vv[0]) chk("R5 update seq", 64'(bpu_seq[15:0]), 64'h0A0A);
      chk("R8 table wait cancel", 64'(wait_cancel[0]), 64'(vv[4] && prev_st == 3'd2));
      prev_st = vv[7:5];
      clr();
    end

    // stall flags and causes
    blk_pulse[5] = 1'b1; @(negedge clk); clr();
    chk("R1 rename t1 flag", 64'(stall_src), 64'h20);
    chk("R2 stalled t1", 64'(stalled), 64'h2);
    chk("R3 cause rename", 64'(stall_cause[5:3]), 64'd3);
    blk_pulse[4] = 1'b1; @(negedge clk); clr();
    chk("R3 cause decode over rename", 64'(stall_cause[5:3]), 64'd2);
    ctx_switch = 1'b1; #1;
    chk("R2 ctx stalls all", 64'(stalled), 64'h3);
    chk("R3 ctx first", 64'(stall_cause), 64'({3'd1, 3'd1}));
    @(negedge clk); ctx_switch = 1'b0;
    unb_pulse[5:4] = 2'b11; @(negedge clk); clr();
    chk("R1 cleared", 64'({stall_src, stalled}), 64'h0);
    blk_pulse[7:6] = 2'b11; @(negedge clk); clr();
    chk("R3 execute over commit", 64'(stall_cause[5:3]), 64'd4);
    unb_pulse[6] = 1'b1; @(negedge clk); clr();
    chk("R3 commit only", 64'(stall_cause[5:3]), 64'd5);
    unb_pulse[7] = 1'b1; @(negedge clk); clr();
    chk("R3 none", 64'({stall_cause, stalled}), 64'h0);

    // retry slot and wait cancel
    fe_upd[1] = 1'b1; fe_code[5:3] = 3'd2; retry_claim = 1'b1; retry_tid = 1'b1;
    @(negedge clk); clr();
    chk("R10 claim t1", 64'({retry_busy, retry_owner, status[5:3]}), 64'({1'b1, 1'b1, 3'd2}));
    retry_claim = 1'b1; retry_tid = 1'b0; @(negedge clk); clr();
    chk("R10 claim while busy", 64'({retry_busy, retry_owner}), 64'h3);
    cmt_squash[0] = 1'b1; @(negedge clk); clr();
    chk("R8 other thread squash keeps slot", 64'({retry_busy, wait_cancel}), 64'h4);
    cmt_squash[1] = 1'b1; @(negedge clk); clr();
    chk("R8 owner squash frees", 64'({retry_busy, wait_cancel}), 64'h2);
    chk("R4 t1 redirect", 64'({redir_valid, redir_upc[15:8]}), 64'h211);
    chk("R4 t1 pc", 64'(redir_pc[63:32]), 64'h1100);
    chk("R4 t1 npc", 64'(redir_npc[63:32]), 64'h1104);
    fe_upd = 2'b11; fe_code = '0; @(negedge clk); clr();
    retry_claim = 1'b1; retry_tid = 1'b0; @(negedge clk); clr();
    chk("R10 claim t0", 64'({retry_busy, retry_owner}), 64'h2);
    retry_release = 1'b1; @(negedge clk); clr();
    chk("R10 release", 64'(retry_busy), 64'h0);

    // stage activity
    fe_upd = 2'b11; fe_code = {3'd3, 3'd3}; @(negedge clk); clr();
    chk("R11 deactivate", 64'({stage_active, act_pulse, deact_pulse}), 64'h1);
    @(negedge clk);
    chk("R11 deact single", 64'({stage_active, deact_pulse}), 64'h0);
    thread_active = 2'b01; fe_upd[1] = 1'b1; fe_code[5:3] = 3'd0; @(negedge clk); clr();
    chk("R11 inactive thread ignored", 64'({stage_active, act_pulse}), 64'h0);
    fe_upd[0] = 1'b1; fe_code[2:0] = 3'd4; @(negedge clk); clr();
    chk("R11 complete activates", 64'({stage_active, act_pulse}), 64'h3);
    fe_upd[0] = 1'b1; fe_code[2:0] = 3'd6; @(negedge clk); clr();
    chk("R9 illegal code ignored", 64'(status[2:0]), 64'd4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule